// File: doc/BRIEF.md
# Maskable Edge/Level Interrupt Bank

This block gathers up to 32 interrupt source lines into a single request. It presents four word-sized registers to software. An edge source that rises while its enable bit is set latches a sticky event bit, and software clears that bit by writing ones to the acknowledge register. A fixed parameter marks some sources as level-sensitive. These sources never latch an event. They count as pending only while their synchronized line is high.

The block raises one request output whenever any enabled source is pending. It also gives the number of the highest-numbered pending source and a flag that says the number is valid. Each bank decodes a 16-byte slot of a 64-byte register window, so two banks with different base parameters can share one address bus and one set of source lines. Enabling an edge source whose line is already high does not count as a new edge, so it does not raise a request. Software has to check the raw line register to find such a source.

Top module: `irq_bank`

## Requirements
- R1: After reset, the event register and the enable register are zero, the request output is low and the vector valid flag is low.
- R2: Address bits [5:4] must match the bank base (default 0x20) for the bank to respond. Within the bank, byte offset +0x0 is event, +0x4 is enable, +0x8 is acknowledge and +0xC is line state. Address bits [1:0] are ignored. The acknowledge register reads as zero. A read outside the bank's slot returns zero, and a write outside it changes nothing in the bank.
- R3: The enable register reads back the last value written to it.
- R4: The line state register shows each source input after a two-flop synchronizer, whatever the enable bits are. It changes two clock edges after the input changes.
- R5: An edge source's event bit is set by a rising edge of its synchronized line, and only while its enable bit is 1. The bit stays set after the line falls.
- R6: Writing the acknowledge register clears each event bit that is written as 1. Bits written as 0 have no effect. Writes to the event and line state registers have no effect.
- R7: A source inside the level mask (default 0x1ff00000, bits 20 to 28) never sets its event bit. It is pending exactly while its synchronized line is high and it is enabled, so it stops being pending when the line falls, with no acknowledge.
- R8: Setting the enable bit of an edge source whose line is already high does not set its event bit and does not raise the request.
- R9: The pending set is (event OR (line AND level mask)) AND enable. The request output is high when any bit of that set is 1. The 5-bit vector gives the highest-numbered pending bit, and the valid flag is low when the set is empty.
- R10: Writing zero to the enable register drops the request, while event bits already latched are kept.
- R11: Setting the level mask parameter to 0x3ff00000 makes source 29 level-sensitive as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | 32 | Asynchronous interrupt source lines |
| regAddr | input | 6 | Byte address within the shared 64-byte window |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for the addressed word (combinational) |
| irqReq | output | 1 | Request: any enabled source pending |
| vecValid | output | 1 | Vector holds a pending source |
| vecNum | output | 5 | Highest-numbered pending source |

## Verification
The bench builds two banks on one shared bus and one shared set of source lines. The first bank uses the defaults: base 0x20 and level mask 0x1ff00000. The second bank uses base 0x10 and the wider mask 0x3ff00000. With two banks, the bench can show that a write to one bank's slot does not reach the other, and that source 29 behaves as an edge source in one bank and as a level source in the other. A table of line patterns and enable masks drives the priority encoder across its range. Directed cases then cover acknowledge, enabling a line that is already high, level release and disabling all sources.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Word index of each register inside a bank slot (address bits [3:2]).
  localparam logic [1:0] REG_EVENT  = 2'd0;
  localparam logic [1:0] REG_ENABLE = 2'd1;
  localparam logic [1:0] REG_ACK    = 2'd2;
  localparam logic [1:0] REG_LEVEL  = 2'd3;

  // Strobes from the address decoder to the datapath.
  typedef struct packed {
    logic       rdHit;     // address falls in this bank's slot
    logic [1:0] rdSel;     // register word selected
    logic       enWrite;   // load enable register
    logic       ackWrite;  // apply write-one-to-clear on events
  } bank_strobe_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter logic [5:0]  BANK_BASE = 6'h20
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output bank_strobe_t      strb
);

  logic       slotHit;
  logic [1:0] wordSel;

  // A bank slot is 16 bytes: upper address bits pick the slot.
  assign slotHit = (regAddr[ADDR_W-1:4] == BANK_BASE[ADDR_W-1:4]);
  assign wordSel = regAddr[3:2];

  always_comb begin
    strb          = '0;
    strb.rdHit    = slotHit;
    strb.rdSel    = wordSel;
    strb.enWrite  = regWrEn && slotHit && (wordSel == REG_ENABLE);
    strb.ackWrite = regWrEn && slotHit && (wordSel == REG_ACK);
  end

endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int              NSRC        = 32,
  parameter int              SYNC_STAGES = 2,
  parameter logic [NSRC-1:0] LEVEL_MASK  = 32'h1ff0_0000,
  localparam int             VEC_W       = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  srcIn,
  input  logic [NSRC-1:0]  regWrData,
  input  bank_strobe_t     strb,
  output logic [NSRC-1:0]  regRdData,
  output logic [NSRC-1:0]  eventQ,
  output logic [NSRC-1:0]  enableQ,
  output logic [NSRC-1:0]  levelQ,
  output logic             irqReq,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecNum
);

  logic [NSRC-1:0] syncQ [SYNC_STAGES];
  logic [NSRC-1:0] prevQ;
  logic [NSRC-1:0] riseBits;
  logic [NSRC-1:0] ackBits;
  logic [NSRC-1:0] pendBits;

  // Synchronizer chain, one register stage per generate step.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= srcIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign levelQ   = syncQ[SYNC_STAGES-1];
  assign riseBits = levelQ & ~prevQ;
  assign ackBits  = strb.ackWrite ? regWrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= '0;
      eventQ  <= '0;
      enableQ <= '0;
    end else begin
      prevQ   <= levelQ;
      // A fresh edge wins over an acknowledge in the same cycle.
      eventQ  <= (eventQ & ~ackBits) | (riseBits & enableQ & ~LEVEL_MASK);
      if (strb.enWrite) enableQ <= regWrData;
    end
  end

  assign pendBits = (eventQ | (levelQ & LEVEL_MASK)) & enableQ;
  assign irqReq   = |pendBits;
  assign vecValid = irqReq;

  // Highest-numbered pending bit wins: later indices overwrite.
  always_comb begin
    vecNum = '0;
    for (int i = 0; i < NSRC; i++)
      if (pendBits[i]) vecNum = VEC_W'(i);
  end

  always_comb begin
    regRdData = '0;
    if (strb.rdHit) begin
      case (strb.rdSel)
        REG_EVENT:  regRdData = eventQ;
        REG_ENABLE: regRdData = enableQ;
        REG_LEVEL:  regRdData = levelQ;
        default:    regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter logic [5:0]  BANK_BASE  = 6'h20,
  parameter logic [31:0] LEVEL_MASK = 32'h1ff0_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] srcIn,
  input  logic [5:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irqReq,
  output logic        vecValid,
  output logic [4:0]  vecNum
);

  bank_strobe_t strb;
  logic [31:0]  eventQ;
  logic [31:0]  enableQ;
  logic [31:0]  levelQ;

  irq_bank_ctrl #(
    .ADDR_W    (6),
    .BANK_BASE (BANK_BASE)
  ) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  irq_bank_dp #(
    .NSRC        (32),
    .SYNC_STAGES (2),
    .LEVEL_MASK  (LEVEL_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .regWrData (regWrData),
    .strb      (strb),
    .regRdData (regRdData),
    .eventQ    (eventQ),
    .enableQ   (enableQ),
    .levelQ    (levelQ),
    .irqReq    (irqReq),
    .vecValid  (vecValid),
    .vecNum    (vecNum)
  );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter logic [5:0]  BANK_BASE  = 6'h20,
  parameter logic [31:0] LEVEL_MASK = 32'h1ff0_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  regAddr,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic [31:0] eventQ,
  input logic [31:0] enableQ,
  input logic [31:0] levelQ,
  input logic        irqReq,
  input logic        vecValid,
  input logic [4:0]  vecNum
);

  localparam logic [5:0] EN_ADDR = {BANK_BASE[5:4], 4'h4};

  // R3: a write to the enable word is visible on the next cycle
  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == EN_ADDR) |=> (enableQ == $past(regWrData)));

  // R5: a newly set event bit must have been enabled the cycle before
  a_r5_event_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((eventQ & ~$past(eventQ) & ~$past(enableQ)) == 32'h0));

  // R7: level-sensitive sources never hold an event bit
  a_r7_level_no_event: assert property (@(posedge clk) disable iff (!rstN)
    ((eventQ & LEVEL_MASK) == 32'h0));

  // R9: the reported vector points at an enabled, pending source
  a_r9_vec_pending: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (enableQ[vecNum] &&
                  (eventQ[vecNum] || (levelQ[vecNum] && LEVEL_MASK[vecNum]))));

  // R9: request and valid flag agree
  a_r9_req_valid: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> vecValid);

  // R10: no request while every source is disabled
  a_r10_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == 32'h0) |-> !irqReq);

endmodule

bind irq_bank irq_bank_chk #(
  .BANK_BASE  (BANK_BASE),
  .LEVEL_MASK (LEVEL_MASK)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .eventQ    (eventQ),
  .enableQ   (enableQ),
  .levelQ    (levelQ),
  .irqReq    (irqReq),
  .vecValid  (vecValid),
  .vecNum    (vecNum)
);

// File: tb/irq_bank_tb.sv
`timescale 1ns/1ps
module irq_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1, val0, val1;
  logic [4:0]  vec0, vec1;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irq_bank #(.BANK_BASE(6'h20), .LEVEL_MASK(32'h1ff0_0000)) u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(rd0),
    .irqReq(irq0), .vecValid(val0), .vecNum(vec0));

  irq_bank #(.BANK_BASE(6'h10), .LEVEL_MASK(32'h3ff0_0000)) u_dut1 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(rd1),
    .irqReq(irq1), .vecValid(val1), .vecNum(vec1));

  // {source pattern, enable mask, expected valid, expected vector}
  localparam int NV = 8;
  localparam logic [69:0] VECS [NV] = '{
    {32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 5'd0},
    {32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 5'd31},
    {32'h8000_0001, 32'h7FFF_FFFF, 1'b1, 5'd0},
    {32'h0010_0000, 32'h0010_0000, 1'b1, 5'd20},
    {32'h00F0_F000, 32'h0000_F000, 1'b1, 5'd15},
    {32'h1234_5678, 32'h0000_0000, 1'b0, 5'd0},
    {32'h0000_FF00, 32'hFFFF_00FF, 1'b0, 5'd0},
    {32'h4000_0000, 32'hC000_0000, 1'b1, 5'd30}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk);
    regAddr = a;
    #1;
    d0 = rd0; d1 = rd1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] a, b;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1: reset state
    regRead(6'h20, a, b); check("R1 event after reset", a, 32'h0);
    regRead(6'h24, a, b); check("R1 enable after reset", a, 32'h0);
    check("R1 irq after reset", {31'h0, irq0}, 32'h0);
    check("R1 valid after reset", {31'h0, val0}, 32'h0);

    // R9: priority table
    foreach (VECS[k]) begin
      srcIn = '0;
      regWrite(6'h24, 32'h0);
      regWrite(6'h28, 32'hFFFF_FFFF);
      waitCyc(4);
      regWrite(6'h24, VECS[k][37:6]);
      srcIn = VECS[k][69:38];
      waitCyc(4);
      check($sformatf("R9 irq vec%0d", k), {31'h0, irq0}, {31'h0, VECS[k][5]});
      check($sformatf("R9 valid vec%0d", k), {31'h0, val0}, {31'h0, VECS[k][5]});
      if (VECS[k][5])
        check($sformatf("R9 number vec%0d", k), {27'h0, vec0}, {27'h0, VECS[k][4:0]});
    end

    // clean slate
    srcIn = '0;
    regWrite(6'h24, 32'h0);
    regWrite(6'h28, 32'hFFFF_FFFF);
    waitCyc(4);

    // R3: enable readback
    regWrite(6'h24, 32'hA5A5_0F0F);
    regRead(6'h24, a, b); check("R3 enable readback", a, 32'hA5A5_0F0F);
    regWrite(6'h24, 32'h0);

    // R4: raw line state, disabled, two-edge latency
    @(negedge clk); srcIn = 32'h0000_0300;
    regAddr = 6'h2C;
    @(negedge clk); #1; check("R4 level one edge", rd0, 32'h0);
    @(negedge clk); #1; check("R4 level two edges", rd0, 32'h0000_0300);
    check("R4 no irq when disabled", {31'h0, irq0}, 32'h0);
    srcIn = '0; waitCyc(4);

    // R8: enabling an already-active edge source
    srcIn = 32'h0000_0008; waitCyc(4);
    regWrite(6'h24, 32'h0000_0008);
    waitCyc(4);
    regRead(6'h20, a, b); check("R8 no event", a, 32'h0);
    check("R8 no irq", {31'h0, irq0}, 32'h0);
    srcIn = '0; waitCyc(4);

    // R5: event latches and holds after line drops
    regWrite(6'h24, 32'h0000_0020);
    srcIn = 32'h0000_0020; waitCyc(4);
    srcIn = '0; waitCyc(4);
    regRead(6'h20, a, b); check("R5 event held", a, 32'h0000_0020);
    check("R5 irq held", {31'h0, irq0}, 32'h1);
    check("R5 vector", {27'h0, vec0}, 32'd5);

    // R6: write-one-to-clear, zero bits no effect, event write ignored
    regWrite(6'h28, 32'h0000_0001);
    regRead(6'h20, a, b); check("R6 zero bits keep event", a, 32'h0000_0020);
    regWrite(6'h20, 32'h0);
    regRead(6'h20, a, b); check("R6 event write ignored", a, 32'h0000_0020);
    regWrite(6'h2C, 32'hFFFF_FFFF);
    regRead(6'h2C, a, b); check("R6 level write ignored", a, 32'h0);

    // R10: disable all keeps event but drops request
    regWrite(6'h24, 32'h0);
    check("R10 irq dropped", {31'h0, irq0}, 32'h0);
    regRead(6'h20, a, b); check("R10 event kept", a, 32'h0000_0020);
    regWrite(6'h24, 32'h0000_0020);
    check("R10 irq back", {31'h0, irq0}, 32'h1);
    regWrite(6'h28, 32'h0000_0020);
    regRead(6'h20, a, b); check("R6 ack clears", a, 32'h0);
    check("R6 irq cleared", {31'h0, irq0}, 32'h0);

    // R7: level source follows its line without ack
    regWrite(6'h24, 32'h0020_0000);
    srcIn = 32'h0020_0000; waitCyc(4);
    check("R7 level irq", {31'h0, irq0}, 32'h1);
    check("R7 level vector", {27'h0, vec0}, 32'd21);
    regRead(6'h20, a, b); check("R7 no event", a, 32'h0);
    srcIn = '0; waitCyc(4);
    check("R7 released", {31'h0, irq0}, 32'h0);
    regWrite(6'h24, 32'h0);

    // R2: bank decode on the shared window
    regWrite(6'h14, 32'h2000_0000);
    regRead(6'h24, a, b); check("R2 bank0 untouched", a, 32'h0);
    regRead(6'h14, a, b);
    check("R2 bank0 reads zero outside slot", a, 32'h0);
    check("R2 bank1 enable", b, 32'h2000_0000);
    regRead(6'h28, a, b); check("R2 ack reads zero", a, 32'h0);
    regRead(6'h27, a, b); check("R2 low bits ignored", a, 32'h0);

    // R11: bit 29 is level in bank1, edge in bank0
    regWrite(6'h24, 32'h2000_0000);
    srcIn = 32'h2000_0000; waitCyc(4);
    check("R11 bank1 irq", {31'h0, irq1}, 32'h1);
    check("R11 bank1 vector", {27'h0, vec1}, 32'd29);
    regRead(6'h10, a, b); check("R11 bank1 no event", b, 32'h0);
    regRead(6'h20, a, b); check("R11 bank0 edge event", a, 32'h2000_0000);
    srcIn = '0; waitCyc(4);
    check("R11 bank1 released", {31'h0, irq1}, 32'h0);
    check("R11 bank0 still pending", {31'h0, irq0}, 32'h1);

    done = 1'b1;
    summary();
  end

endmodule